// File: doc/BRIEF.md
# Memory-Path Self-Test Traffic Engine

The engine exercises a buffering path by sending it a known stream of words and checking the words that come back. A counting pattern drives the outgoing valid/ready stream: word k of a run carries k modulo 2^DATA_W. The incoming stream is compared word by word against the same sequence. Software controls the engine through a small word-addressed register port. The port offers:

- a byte-count setting;
- a control register with self-clearing start, stop and clear strobes and a stored continuous-mode bit;
- read-only counters for words sent, words received, elapsed cycles and mismatches;
- a read-only clock-rate register.

Software can divide a word count by the cycle count and scale the result by the clock rate to get throughput.

A run either ends by itself once every configured word has gone out and come back, or it runs in continuous mode until a stop strobe arrives. The memory under test is not part of the block. It sits between the outgoing port `tx_*` and the incoming port `rx_*`.

Register map (byte offsets):

| Offset | Access | Contents |
|---|---|---|
| 0x00 | read | status, bit 0 = running |
| 0x04 | read/write | byte count |
| 0x08 | read | words sent |
| 0x0C | read | words received |
| 0x10 | read | cycles |
| 0x14 | read | mismatches |
| 0x18 | read | clock rate in Hz |
| 0x30 | read/write | control |

Control register bits:

| Bit | Function |
|---|---|
| 0 | start |
| 1 | stop |
| 2 | clear |
| 3 | continuous |

Top module: `mem_bist_engine`

## Requirements
- R1: After reset the status bit (0x00 bit 0) is 0, the four counters (0x08, 0x0C, 0x10, 0x14) read 0, and `tx_valid` is low.
- R2: A start strobe (write to 0x30 with bit 0 set) while idle begins a run of byte count / (DATA_W/8) words. Word k sent and expected carries k modulo 2^DATA_W, and `tx_data` holds steady while `tx_valid` waits on `tx_ready`.
- R3: With continuous mode off, the run ends by itself once all words have been sent and received. The status bit then returns to 0, and 0x08 and 0x0C each read the word count.
- R4: With control bit 3 set at the start strobe, the run continues past the word count until a stop strobe (bit 1). After that, `tx_valid` stays low and the counters hold.
- R5: A control write with both bit 0 and bit 1 set does not start a run, and it stops a run that is in progress.
- R6: A start strobe while a run is in progress is ignored. The run keeps its mode and its counters, and they are not reset.
- R7: A clear strobe (bit 2) sets the sent, received, cycle and mismatch counters to 0. A start strobe that is accepted also sets them to 0.
- R8: The cycle counter adds one for every clock edge at which a run was in progress, and holds while idle. For a fixed run of n words looped back through a one-cycle FIFO that never stalls, the count is n+2 for n of 1 or more, and 1 for n = 0.
- R9: Each received word that differs from the expected pattern adds exactly one to the mismatch counter.
- R10: Control bits 2:0 read back as 0. Control bit 3 reads back as the last value written to it.
- R11: Register 0x18 reads CLK_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | ADDR_W | register byte offset |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr (combinational) |
| tx_valid | output | 1 | outgoing word valid |
| tx_ready | input | 1 | outgoing word accepted |
| tx_data | output | DATA_W | outgoing pattern word |
| rx_valid | input | 1 | returned word valid |
| rx_ready | output | 1 | engine accepts returned word |
| rx_data | input | DATA_W | returned word |

## Verification
The bench builds the engine with DATA_W = 8, so one word is one byte and the pattern wraps after 256 words. The bench sweeps every fixed-run length from 0 to 20, plus 255, 256 and 300, and checks the sent, received, mismatch and cycle counts against the n+2 formula. The narrow word brings the pattern wrap within reach of both fixed and continuous runs. Further runs add a stalling loopback and one corrupted word. Single control writes exercise the strobe priority, the busy-start case and the readback.

// File: rtl/mem_bist_engine.sv
`timescale 1ns/1ps
module mem_bist_engine #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int CLK_HZ = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data
);
  localparam int BSH = $clog2(DATA_W / 8);

  logic             running, run_cont, cont_cfg;
  logic [CNT_W-1:0] byte_cnt, run_words, tx_idx, rx_idx;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, cyc_cnt, err_cnt;

  wire ctrl_wr = reg_wr && reg_addr == ADDR_W'(8'h30);
  wire halt    = ctrl_wr && reg_wdata[1];
  wire go      = ctrl_wr && reg_wdata[0] && !reg_wdata[1] && !running;
  wire clr     = ctrl_wr && reg_wdata[2];
  wire tx_fire = tx_valid && tx_ready;
  wire rx_fire = rx_valid && rx_ready;
  wire bad     = rx_fire && rx_data != rx_idx[DATA_W-1:0];
  wire done    = running && !run_cont && tx_idx == run_words && rx_idx == run_words;

  assign tx_valid = running && (run_cont || tx_idx < run_words);
  assign tx_data  = tx_idx[DATA_W-1:0];
  assign rx_ready = running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      run_cont  <= 1'b0;
      cont_cfg  <= 1'b0;
      byte_cnt  <= '0;
      run_words <= '0;
      tx_idx    <= '0;
      rx_idx    <= '0;
      tx_cnt    <= '0;
      rx_cnt    <= '0;
      cyc_cnt   <= '0;
      err_cnt   <= '0;
    end else begin
      if (ctrl_wr) cont_cfg <= reg_wdata[3];
      if (reg_wr && reg_addr == ADDR_W'(8'h04)) byte_cnt <= CNT_W'(reg_wdata);

      if (go) begin
        running   <= 1'b1;
        run_cont  <= reg_wdata[3];
        run_words <= byte_cnt >> BSH;
        tx_idx    <= '0;
        rx_idx    <= '0;
      end else begin
        if (halt || done) running <= 1'b0;
        if (tx_fire) tx_idx <= tx_idx + 1'b1;
        if (rx_fire) rx_idx <= rx_idx + 1'b1;
      end

      if (go || clr) begin
        tx_cnt  <= '0;
        rx_cnt  <= '0;
        cyc_cnt <= '0;
        err_cnt <= '0;
      end else begin
        if (tx_fire) tx_cnt  <= tx_cnt + 1'b1;
        if (rx_fire) rx_cnt  <= rx_cnt + 1'b1;
        if (running) cyc_cnt <= cyc_cnt + 1'b1;
        if (bad)     err_cnt <= err_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(8'h00): reg_rdata = {31'd0, running};
      ADDR_W'(8'h04): reg_rdata = 32'(byte_cnt);
      ADDR_W'(8'h08): reg_rdata = 32'(tx_cnt);
      ADDR_W'(8'h0C): reg_rdata = 32'(rx_cnt);
      ADDR_W'(8'h10): reg_rdata = 32'(cyc_cnt);
      ADDR_W'(8'h14): reg_rdata = 32'(err_cnt);
      ADDR_W'(8'h18): reg_rdata = 32'(CLK_HZ);
      ADDR_W'(8'h30): reg_rdata = {28'd0, cont_cfg, 3'd0};
      default:        reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mem_bist_engine_chk.sv
`timescale 1ns/1ps
module mem_bist_engine_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              running,
  input logic [CNT_W-1:0]  cyc_cnt,
  input logic [CNT_W-1:0]  err_cnt
);
  logic cw;
  assign cw = reg_wr && reg_addr == ADDR_W'(8'h30);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tx_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !(cw && reg_wdata[1]) |=> tx_valid && $stable(tx_data));

  p_stop_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cw && reg_wdata[1] |=> !running);

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running && cw && reg_wdata[0] && !reg_wdata[1] |=> running);

  p_cyc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cw |=> $stable(cyc_cnt));

  p_err_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cw |=> err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1'b1);
endmodule

bind mem_bist_engine mem_bist_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .running(running), .cyc_cnt(cyc_cnt), .err_cnt(err_cnt)
);

// File: tb/mem_bist_engine_tb.sv
`timescale 1ns/1ps
module mem_bist_engine_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          tx_valid, tx_ready, rx_valid, rx_ready;
  logic [DW-1:0] tx_data, rx_data;

  int checks = 0, errors = 0;
  logic flush = 1'b0, stall_mode = 1'b0, stall_ph = 1'b0;
  int corrupt_at = -1;

  always #5 clk = ~clk;

  mem_bist_engine #(.DATA_W(DW), .CNT_W(32), .ADDR_W(8), .CLK_HZ(100_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data));

  logic [DW-1:0] mem [0:1023];
  int wp = 0, rp = 0, pushes = 0;
  assign rx_valid = wp != rp;
  assign rx_data  = mem[rp % 1024];
  assign tx_ready = !(stall_mode && stall_ph) && (wp - rp) < 1000;

  always @(posedge clk) begin
    stall_ph <= ~stall_ph;
    if (flush) begin
      wp <= 0; rp <= 0; pushes <= 0;
    end else begin
      if (tx_valid && tx_ready) begin
        mem[wp % 1024] <= (pushes == corrupt_at) ? ~tx_data : tx_data;
        wp <= wp + 1;
        pushes <= pushes + 1;
      end
      if (rx_valid && rx_ready) rp <= rp + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(8'h00, s);
      if (s[0] == 1'b0) return;
      @(negedge clk);
    end
  endtask

  task automatic fixed_run(input int n, input bit check_cyc);
    logic [31:0] t, r, e, c;
    do_flush();
    wr(8'h04, n);
    wr(8'h30, 32'h1);
    wait_idle(5000);
    rd(8'h00, t);
    chk(t[0] == 1'b0, "R3 run ends", t[0], 0);
    rd(8'h08, t); rd(8'h0C, r); rd(8'h14, e); rd(8'h10, c);
    chk(t == n && r == n, "R3 sent/received words", t * 100000 + r, n * 100000 + n);
    chk(e == 0, "R2 pattern mismatches", e, 0);
    if (check_cyc) chk(c == ((n == 0) ? 1 : n + 2), "R8 cycle count", c, (n == 0) ? 1 : n + 2);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h00, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h08, v); chk(v == 0, "R1 sent", v, 0);
    rd(8'h0C, v); chk(v == 0, "R1 received", v, 0);
    rd(8'h10, v); chk(v == 0, "R1 cycles", v, 0);
    rd(8'h14, v); chk(v == 0, "R1 errors", v, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);

    rd(8'h18, v); chk(v == 100_000_000, "R11 clock rate", v, 100_000_000);

    for (int n = 0; n <= 20; n++) fixed_run(n, 1'b1);
    fixed_run(255, 1'b1);
    fixed_run(256, 1'b1);
    fixed_run(300, 1'b1);

    stall_mode = 1'b1;
    fixed_run(16, 1'b0);
    stall_mode = 1'b0;

    corrupt_at = 3;
    do_flush();
    wr(8'h04, 10);
    wr(8'h30, 32'h1);
    wait_idle(500);
    rd(8'h14, v); chk(v == 1, "R9 one corrupted word", v, 1);
    corrupt_at = -1;

    wr(8'h30, 32'h4);
    rd(8'h08, v); chk(v == 0, "R7 clear sent", v, 0);
    rd(8'h0C, v); chk(v == 0, "R7 clear received", v, 0);
    rd(8'h10, v); chk(v == 0, "R7 clear cycles", v, 0);
    rd(8'h14, v); chk(v == 0, "R7 clear errors", v, 0);
    rd(8'h30, v); chk(v == 0, "R10 strobes read zero", v, 0);
    repeat (5) @(negedge clk);
    rd(8'h10, v); chk(v == 0, "R8 idle cycles hold", v, 0);

    wr(8'h30, 32'h8);
    rd(8'h30, v); chk(v == 8, "R10 continuous bit reads back", v, 8);
    rd(8'h00, v); chk(v == 0, "R10 mode write does not start", v, 0);
    wr(8'h30, 32'h0);
    rd(8'h30, v); chk(v == 0, "R10 continuous bit cleared", v, 0);

    do_flush();
    wr(8'h30, 32'h3);
    repeat (4) @(negedge clk);
    rd(8'h00, v); chk(v == 0, "R5 stop beats start", v, 0);
    rd(8'h08, v); chk(v == 0, "R5 no words sent", v, 0);

    do_flush();
    wr(8'h04, 20);
    wr(8'h30, 32'h9);
    repeat (300) @(negedge clk);
    rd(8'h00, v); chk(v == 1, "R4 continuous still running", v, 1);
    rd(8'h08, a); chk(a > 20, "R4 runs past word count", a, 21);
    wr(8'h30, 32'h1);
    rd(8'h08, b); chk(b >= a, "R6 busy start keeps counters", b, a);
    repeat (50) @(negedge clk);
    rd(8'h00, v); chk(v == 1, "R6 busy start keeps mode", v, 1);
    rd(8'h14, v); chk(v == 0, "R2 pattern across wrap", v, 0);
    wr(8'h30, 32'h2);
    rd(8'h00, v); chk(v == 0, "R4 stop ends run", v, 0);
    chk(tx_valid == 1'b0, "R4 tx idle after stop", tx_valid, 0);
    rd(8'h08, a); rd(8'h10, b);
    repeat (10) @(negedge clk);
    rd(8'h08, v); chk(v == a, "R4 sent holds after stop", v, a);
    rd(8'h10, v); chk(v == b, "R8 cycles hold after stop", v, b);

    do_flush();
    wr(8'h04, 0);
    wr(8'h30, 32'h9);
    repeat (20) @(negedge clk);
    wr(8'h30, 32'h3);
    rd(8'h00, v); chk(v == 0, "R5 stop with start halts run", v, 0);
    rd(8'h14, v); chk(v == 0, "R9 no mismatches on clean path", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule